// File: doc/BRIEF.md
# H4 Multiframe Alignment Machine

This block follows the low-order multiframe phase carried in the path overhead H4 byte. Each time a frame strobe arrives with a new H4 value, the block looks at the low sequence bits. While hunting, it waits for two back-to-back frames whose sequence values are consecutive in the count, and the count wraps. Once aligned, it runs a local phase counter that moves on by one per frame. Each received value is compared with that counter.

A single frame that disagrees with the local counter drops the in-frame status, but the alignment is kept. Loss of multiframe is declared only when the disagreement persists for two whole multiframes. At that point the block goes back to hunting. A correct frame during a run of disagreements restores the in-frame status and restarts the run.

A one-cycle H4 enable marker tells the downstream bus that the local phase has reached its terminal value. This marker appears only while the block is aligned and in frame. The loss state always holds the marker low.

Top module: `h4_mf_align`

## Requirements
- R1: After reset the outputs are: `phase`=0, `in_frame`=0, `lom`=1 and `h4_en`=0.
- R2: While hunting, a frame whose sequence value (H4 bits [1:0]) equals the previous frame's value plus one, modulo 4, achieves alignment. In the cycle after that strobe, `in_frame`=1, `lom`=0 and `phase` equals the received value. H4 bits [7:2] have no effect.
- R3: While hunting, the following do not align: a single frame, or a frame whose value does not follow on from the previous one. Each such frame loads its own value into `phase`, and `in_frame` stays 0 and `lom` stays 1.
- R4: The sequence wraps, so value 0 following value 3 counts as adjacent. This holds for acquisition and for the local counter.
- R5: While aligned, every frame strobe advances `phase` by one, modulo 4, whatever value is received.
- R6: While aligned, a frame whose value differs from the advanced local phase clears `in_frame` in the next cycle. `lom` stays 0 unless R7 applies.
- R7: The 8th consecutive disagreeing frame (two multiframes) sets `lom`=1, with `in_frame`=0, and returns the block to hunting. Alignment then again needs two adjacent frames.
- R8: A frame that agrees with the local phase while aligned sets `in_frame`=1 and restarts the disagreement run. Seven disagreements, one agreement and seven more disagreements do not declare loss.
- R9: `h4_en` is a one-cycle pulse in the cycle after a strobe that leaves `phase`=3 with `in_frame`=1 and `lom`=0. `h4_en` is never high while `lom` is 1 or `in_frame` is 0.
- R10: Without a frame strobe, `phase`, `in_frame` and `lom` hold their values and `h4_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe marking a new frame's H4 byte |
| h4_byte | input | 8 | Received H4 byte, valid with `frame_stb` |
| phase | output | 2 | Current multiframe phase |
| in_frame | output | 1 | Last frame agreed with the aligned phase |
| lom | output | 1 | Loss of multiframe flag |
| h4_en | output | 1 | One-cycle marker at the terminal phase |

## Verification
The checker enforces several rules on every cycle:
- the enable marker is never high during loss or out of frame, and it only follows a strobe at phase 3;
- the outputs stay still between strobes;
- the phase advances by one per strobe while in frame;
- loss can only rise after the in-frame status has already fallen;
- in-frame can only rise on a strobe.

Some behaviours depend on a history of frames and can only be shown by the bench's scenarios:
- the exact frame count of eight before loss, and the restart of that count by a single correct frame;
- rejection of non-adjacent pairs while hunting;
- wrap-around acquisition;
- the fact that the upper H4 bits are ignored.

// File: rtl/h4_mf_pkg.sv
package h4_mf_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_SYNC = 1'b1
  } h4_state_e;
endpackage

// File: rtl/h4_seq_adj.sv
// Combinational test: does cur follow prev by one in a wrapping count?
module h4_seq_adj #(
  parameter int SEQ_W = 2
) (
  input  logic [SEQ_W-1:0] prev,
  input  logic [SEQ_W-1:0] cur,
  output logic             adj
);
  logic [SEQ_W-1:0] succ;

  always_comb begin
    succ = prev + 1'b1;
    adj  = (cur == succ);
  end
endmodule

// File: rtl/h4_miss_ctr.sv
// Counts consecutive disagreeing frames; last flags that one more miss reaches LIMIT.
module h4_miss_ctr #(
  parameter int LIMIT = 8,
  localparam int CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic last
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (clr) cnt_d = '0;
      else     cnt_d = cnt_q + 1'b1;
    end
    last = (cnt_q == CW'(LIMIT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/h4_mf_align.sv
module h4_mf_align #(
  parameter int BYTE_W      = 8,
  parameter int SEQ_W       = 2,
  parameter int LOSS_FRAMES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [BYTE_W-1:0] h4_byte,
  output logic [SEQ_W-1:0]  phase,
  output logic              in_frame,
  output logic              lom,
  output logic              h4_en
);
  import h4_mf_pkg::*;

  localparam logic [SEQ_W-1:0] PH_LAST = {SEQ_W{1'b1}};

  h4_state_e        st_q, st_d;
  logic [SEQ_W-1:0] ph_q, ph_d;
  logic             have_q, have_d;
  logic             inf_q, inf_d;
  logic             lom_q, lom_d;
  logic             en_q, en_d;

  logic [SEQ_W-1:0] rx_seq;
  logic [SEQ_W-1:0] ph_adv;
  logic             rx_adj;
  logic             sync_stb;
  logic             agree;
  logic             miss_last;
  logic             lose;

  assign rx_seq   = h4_byte[SEQ_W-1:0];
  assign ph_adv   = ph_q + 1'b1;
  assign sync_stb = frame_stb && (st_q == ST_SYNC);
  assign agree    = (rx_seq == ph_adv);
  assign lose     = sync_stb && !agree && miss_last;

  h4_seq_adj #(.SEQ_W(SEQ_W)) u_adj (
    .prev (ph_q),
    .cur  (rx_seq),
    .adj  (rx_adj)
  );

  h4_miss_ctr #(.LIMIT(LOSS_FRAMES)) u_miss (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sync_stb),
    .clr   (agree || miss_last),
    .last  (miss_last)
  );

  // next-state process
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    have_d = have_q;
    inf_d  = inf_q;
    lom_d  = lom_q;
    en_d   = 1'b0;
    if (frame_stb) begin
      if (st_q == ST_HUNT) begin
        ph_d = rx_seq;
        if (have_q && rx_adj) begin
          st_d  = ST_SYNC;
          inf_d = 1'b1;
          lom_d = 1'b0;
        end else begin
          have_d = 1'b1;
        end
      end else begin
        ph_d  = ph_adv;
        inf_d = agree;
        if (lose) begin
          st_d   = ST_HUNT;
          lom_d  = 1'b1;
          have_d = 1'b0;
        end
      end
      en_d = inf_d && !lom_d && (ph_d == PH_LAST);
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      ph_q   <= '0;
      have_q <= 1'b0;
      inf_q  <= 1'b0;
      lom_q  <= 1'b1;
      en_q   <= 1'b0;
    end else begin
      en_q <= en_d;
      if (frame_stb) begin
        st_q   <= st_d;
        ph_q   <= ph_d;
        have_q <= have_d;
        inf_q  <= inf_d;
        lom_q  <= lom_d;
      end
    end
  end

  assign phase    = ph_q;
  assign in_frame = inf_q;
  assign lom      = lom_q;
  assign h4_en    = en_q;
endmodule

// File: rtl/h4_mf_checker.sv
module h4_mf_checker #(
  parameter int SEQ_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_stb,
  input logic [SEQ_W-1:0] phase,
  input logic             in_frame,
  input logic             lom,
  input logic             h4_en
);
  // R9: marker suppressed during loss or out of frame
  assert_en_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    h4_en |-> (!lom && in_frame));

  // R9: marker only after a strobe, at the terminal phase
  assert_en_terminal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h4_en) |-> ($past(frame_stb) && (phase == {SEQ_W{1'b1}})));

  // R10: nothing moves without a strobe
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(phase) && $stable(in_frame) && $stable(lom) && !h4_en));

  // R5: phase advances by one per strobe while in frame
  assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && frame_stb) |=> (phase == SEQ_W'($past(phase) + 1'b1)));

  // R7: loss is only reached through an out-of-frame run
  assert_loss_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lom) |-> (!in_frame && !$past(in_frame)));

  // R2: alignment only on a strobe
  assert_acq_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(frame_stb));

  // R6: in-frame and loss never together
  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |-> !lom);
endmodule

bind h4_mf_align h4_mf_checker #(.SEQ_W(SEQ_W)) u_h4_mf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_stb (frame_stb),
  .phase     (phase),
  .in_frame  (in_frame),
  .lom       (lom),
  .h4_en     (h4_en)
);

// File: tb/test_h4_mf_align.sv
module test_h4_mf_align;
  typedef struct {
    logic [1:0] ph;
    logic       inf;
    logic       lm;
    logic       en;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [7:0] h4_byte = 8'h00;
  logic [1:0] phase;
  logic       in_frame, lom, h4_en;

  int errors = 0;
  int checks = 0;

  exp_t q[$];
  exp_t last_e;
  logic stb_seen = 1'b0;
  logic mon_on   = 1'b0;

  // reference state
  logic       m_sync = 0, m_have = 0, m_inf = 0, m_lom = 1;
  logic [1:0] m_ph = 0;
  int         m_miss = 0;
  int         nfrm = 0;

  always #4 clk = ~clk;

  h4_mf_align i_h4_mf_align (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .h4_byte(h4_byte),
    .phase(phase), .in_frame(in_frame), .lom(lom), .h4_en(h4_en)
  );

  always @(posedge clk) stb_seen <= frame_stb;

  task automatic cmp(exp_t e, logic en_exp);
    checks++;
    if (phase !== e.ph || in_frame !== e.inf || lom !== e.lm || h4_en !== en_exp) begin
      errors++;
      $display("FAIL %s: got ph=%0d inf=%0b lom=%0b en=%0b exp ph=%0d inf=%0b lom=%0b en=%0b",
               e.req, phase, in_frame, lom, h4_en, e.ph, e.inf, e.lm, en_exp);
    end
  endtask

  // monitor: pops after each strobe, checks hold (R10) on idle cycles
  always @(negedge clk) begin
    if (mon_on) begin
      if (stb_seen) begin
        if (q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R10: output update with empty queue");
        end else begin
          last_e = q.pop_front();
          cmp(last_e, last_e.en);
        end
      end else begin
        exp_t h;
        h = last_e;
        h.req = "R10";
        cmp(h, 1'b0);
      end
    end
  end

  task automatic send(input logic [7:0] v, input string req);
    exp_t e;
    logic [1:0] s;
    logic [1:0] np;
    s = v[1:0];
    @(negedge clk);
    frame_stb = 1'b1;
    h4_byte   = v;
    if (!m_sync) begin
      if (m_have && s == m_ph + 2'd1) begin
        m_sync = 1; m_inf = 1; m_lom = 0; m_miss = 0;
      end else begin
        m_have = 1;
      end
      m_ph = s;
    end else begin
      np = m_ph + 2'd1;
      if (s == np) begin
        m_inf = 1; m_miss = 0;
      end else begin
        m_inf = 0; m_miss++;
        if (m_miss == 8) begin
          m_sync = 0; m_lom = 1; m_have = 0; m_miss = 0;
        end
      end
      m_ph = np;
    end
    e.ph = m_ph; e.inf = m_inf; e.lm = m_lom;
    e.en = m_inf && !m_lom && (m_ph == 2'd3);
    e.req = req;
    q.push_back(e);
    @(negedge clk);
    frame_stb = 1'b0;
    h4_byte   = 8'h00;
    nfrm++;
    repeat (nfrm % 3) @(negedge clk);
  endtask

  // send n frames agreeing with the local phase
  task automatic good(input int n, input string req);
    for (int i = 0; i < n; i++) send({6'h2A, 2'(m_ph + 2'd1)}, req);
  endtask

  // send n frames disagreeing with the local phase
  task automatic bad(input int n, input string req);
    for (int i = 0; i < n; i++) send({6'h15, 2'(m_ph + 2'd3)}, req);
  endtask

  task automatic run();
    exp_t r;
    repeat (3) @(negedge clk);
    r.ph = 0; r.inf = 0; r.lm = 1; r.en = 0; r.req = "R1";
    cmp(r, 1'b0);                        // R1 reset state
    last_e = r;
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);
    send(8'hC0, "R3");                   // R3 single frame: no alignment
    send(8'h02, "R3");                   // R3 non-adjacent pair
    send(8'h01, "R3");                   // R3 backward step
    send(8'hFE, "R2");                   // R2 adjacent, upper bits ignored
    good(6, "R5");                       // R5 advance, R9 marker at phase 3
    bad(1, "R6");                        // R6 single disagreement
    good(2, "R8");                       // R8 recovery
    send({6'h3F, 2'(m_ph + 2'd2)}, "R5"); // R5 phase advances on any value
    good(1, "R8");
    bad(7, "R8");                        // R8 seven misses, no loss
    good(1, "R8");
    bad(7, "R8");
    good(4, "R9");
    bad(7, "R6");
    bad(1, "R7");                        // R7 8th miss declares loss
    send(8'h01, "R7");                   // R7 hunting again, one frame
    send(8'h03, "R7");                   // R7 non-adjacent, still hunting
    send(8'h80, "R4");                   // R4 wrap 3 -> 0 acquires
    good(5, "R9");
    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R10: %0d results never produced", q.size());
    end
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule